// File: doc/BRIEF.md
# Flash Status Word Masked Update Sequencer

This block performs a masked read-modify-write of the two 8-bit status registers of a serial flash device. It does not shift bits on the serial bus itself. Instead it drives a byte-level command engine through a command/response handshake. A request carries a 16-bit mask, a 16-bit value and a flag that picks a volatile or a persistent update. The block reads the low register and then the high register and joins them into one word. If the masked bits already hold the wanted value, it finishes without writing anything. Otherwise it sends the write-enable opcode that suits the update kind, followed by a status-write command that carries both bytes.

After the write, the block waits. A persistent update polls the device busy bit until it clears or a cycle budget runs out. A volatile update waits a fixed number of quiet cycles. The block then reads both registers again and compares the masked bits. A mismatch reports the word as locked, so the block never assumes that a write took effect. The result comes out as a code together with the last word that was read.

The request and the result are valid/ready streams. The requester may hold `req_valid` high for as long as it likes, and only the cycle with `req_ready` high takes the fields. The block holds `res_valid` and its payload until the consumer raises `res_ready`. While a result waits, no new request is taken, so a stalled consumer holds back the requester. A command leaves on `cmd_valid`/`cmd_ready`. Each command is answered by exactly one `rsp_valid` pulse, which is taken while `rsp_ready` is high.

Top module: `sreg_rmw_seq`

## Requirements
- R1: A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the block is idle with no result pending. Mask, value and kind are captured at that edge.
- R2: Every operation starts with a single-byte read using opcode 0x05, whose byte becomes word bits [7:0]. It is followed by a read using opcode 0x35, whose byte becomes word bits [15:8].
- R3: When (value & mask) equals (current & mask), the result code is 0 (success) and `res_word` is the word just read. No command follows the two reads.
- R4: Immediately before the write, the block sends a write enable with no data bytes. The opcode is 0x06 for a persistent update (`req_volatile`=0) and 0x50 for a volatile one (`req_volatile`=1).
- R5: The write is opcode 0x01 with `cmd_wlen`=2 and `cmd_wdata` = (current & ~mask) | (value & mask). Bits [7:0] are the first data byte and belong to the low register.
- R6: After a persistent write, the block repeats single-byte 0x05 reads until a response has bit 0 clear. It then goes on to the verify reads, so it makes exactly one poll more than there are busy responses.
- R7: If a poll response has bit 0 set and at least `POLL_LIMIT_CYCLES` cycles have passed since the write response, the result code is 2 (timeout) and `res_word` holds the first word read. No further command is sent.
- R8: After a volatile write, the block sends no poll. No command is offered for at least `SETTLE_CYCLES` cycles after the write response.
- R9: After the wait, the block reads 0x05 and then 0x35 again, and `res_word` is this readback. The code is 0 if the masked bits equal (value & mask) and 1 (locked) if they do not.
- R10: `cmd_valid` and its payload stay stable until `cmd_ready`. Each command waits for one response with `rsp_ready` high. `cmd_valid` and `rsp_ready` are never high together.
- R11: `res_valid`, `res_code` and `res_word` stay stable until `res_ready`. After that the block returns to idle.
- R12: During reset and right after it, `req_ready`=1, while `cmd_valid`, `rsp_ready` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_mask | input | 16 | Bits to change |
| req_value | input | 16 | New values for the masked bits |
| req_volatile | input | 1 | 1 = volatile update, 0 = persistent |
| cmd_valid | output | 1 | Command offered to the byte engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 8 | Opcode byte |
| cmd_wlen | output | 2 | Number of data bytes that follow the opcode |
| cmd_wdata | output | 16 | Data bytes, bits [7:0] sent first |
| cmd_read | output | 1 | Command returns one byte |
| rsp_valid | input | 1 | Engine finished a command |
| rsp_ready | output | 1 | Block waiting for a response |
| rsp_data | input | 8 | Byte read, if any |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_code | output | 2 | 0 success, 1 locked, 2 timeout |
| res_word | output | 16 | Last full word read |

## Verification
The bench builds the block with `POLL_LIMIT_CYCLES`=40 and `SETTLE_CYCLES`=6. With those values a device model that stays busy for a few polls reaches success, and one that stays busy for a thousand polls runs out the budget within a few hundred cycles. The short settle window still lets the bench measure the quiet gap after a volatile write. Lock masks in the model make written bits stick, which produces the locked outcome.

// File: rtl/sreg_rmw_pkg.sv
package sreg_rmw_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_READ_LO  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_READ_HI  = 8'h35;
  localparam logic [BYTE_W-1:0] OP_WEN_PERS = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WEN_VOL  = 8'h50;
  localparam logic [BYTE_W-1:0] OP_WRITE_SR = 8'h01;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_LOCKED  = 2'd1,
    RES_TIMEOUT = 2'd2
  } res_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_LO_CMD,
    S_RD_LO_RSP,
    S_RD_HI_CMD,
    S_RD_HI_RSP,
    S_EVAL,
    S_WEN_CMD,
    S_WEN_RSP,
    S_WR_CMD,
    S_WR_RSP,
    S_SETTLE,
    S_POLL_CMD,
    S_POLL_RSP,
    S_DONE
  } state_e;

endpackage

// File: rtl/sreg_word_merge.sv
module sreg_word_merge #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] value,
  output logic [W-1:0] merged,
  output logic         masked_eq
);
  // Per-bit select: a set mask bit takes the new value, a clear one keeps current.
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign merged[b] = mask[b] ? value[b] : cur[b];
  end

  assign masked_eq = ((cur ^ value) & mask) == '0;
endmodule

// File: rtl/sreg_cycle_cnt.sv
module sreg_cycle_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (en && (cnt != '1))      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sreg_rmw_seq.sv
module sreg_rmw_seq
  import sreg_rmw_pkg::*;
#(
  parameter int unsigned POLL_LIMIT_CYCLES = 2000,
  parameter int unsigned SETTLE_CYCLES     = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_mask,
  input  logic [15:0] req_value,
  input  logic        req_volatile,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_op,
  output logic [1:0]  cmd_wlen,
  output logic [15:0] cmd_wdata,
  output logic        cmd_read,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [7:0]  rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [1:0]  res_code,
  output logic [15:0] res_word
);
  localparam int unsigned MAX_WAIT = (POLL_LIMIT_CYCLES > SETTLE_CYCLES) ?
                                     POLL_LIMIT_CYCLES : SETTLE_CYCLES;
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1) + 1;
  localparam logic [CNT_W-1:0] POLL_LIM  = CNT_W'(POLL_LIMIT_CYCLES);
  localparam logic [CNT_W-1:0] SETTLE_LS = CNT_W'((SETTLE_CYCLES > 0) ? SETTLE_CYCLES - 1 : 0);

  state_e             state_q;
  logic [WORD_W-1:0]  mask_q, value_q, word_q;
  logic               vol_q;
  logic               verify_q;
  res_e               code_q;

  logic [WORD_W-1:0]  merged;
  logic               masked_eq;
  logic [CNT_W-1:0]   wait_cnt;
  logic               cnt_clr, cnt_en;

  sreg_word_merge #(.W(WORD_W)) u_merge (
    .cur       (word_q),
    .mask      (mask_q),
    .value     (value_q),
    .merged    (merged),
    .masked_eq (masked_eq)
  );

  assign cnt_clr = (state_q == S_WR_RSP);
  assign cnt_en  = (state_q == S_SETTLE) || (state_q == S_POLL_CMD) ||
                   (state_q == S_POLL_RSP);

  sreg_cycle_cnt #(.W(CNT_W)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (wait_cnt)
  );

  // Command payload is a pure function of state and captured request.
  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_READ_LO;
    cmd_wlen  = 2'd0;
    cmd_wdata = '0;
    cmd_read  = 1'b0;
    unique case (state_q)
      S_RD_LO_CMD, S_POLL_CMD: begin
        cmd_valid = 1'b1;
        cmd_read  = 1'b1;
      end
      S_RD_HI_CMD: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_READ_HI;
        cmd_read  = 1'b1;
      end
      S_WEN_CMD: begin
        cmd_valid = 1'b1;
        cmd_op    = vol_q ? OP_WEN_VOL : OP_WEN_PERS;
      end
      S_WR_CMD: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_WRITE_SR;
        cmd_wlen  = 2'd2;
        cmd_wdata = merged;
      end
      default: ;
    endcase
  end

  assign rsp_ready = (state_q == S_RD_LO_RSP) || (state_q == S_RD_HI_RSP) ||
                     (state_q == S_WEN_RSP)   || (state_q == S_WR_RSP)    ||
                     (state_q == S_POLL_RSP);
  assign req_ready = (state_q == S_IDLE);
  assign res_valid = (state_q == S_DONE);
  assign res_code  = code_q;
  assign res_word  = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      mask_q   <= '0;
      value_q  <= '0;
      word_q   <= '0;
      vol_q    <= 1'b0;
      verify_q <= 1'b0;
      code_q   <= RES_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          mask_q   <= req_mask;
          value_q  <= req_value;
          vol_q    <= req_volatile;
          verify_q <= 1'b0;
          state_q  <= S_RD_LO_CMD;
        end
        S_RD_LO_CMD: if (cmd_ready) state_q <= S_RD_LO_RSP;
        S_RD_LO_RSP: if (rsp_valid) begin
          word_q[BYTE_W-1:0] <= rsp_data;
          state_q            <= S_RD_HI_CMD;
        end
        S_RD_HI_CMD: if (cmd_ready) state_q <= S_RD_HI_RSP;
        S_RD_HI_RSP: if (rsp_valid) begin
          word_q[WORD_W-1:BYTE_W] <= rsp_data;
          state_q                 <= S_EVAL;
        end
        S_EVAL: begin
          if (masked_eq) begin
            code_q  <= RES_OK;
            state_q <= S_DONE;
          end else if (verify_q) begin
            code_q  <= RES_LOCKED;
            state_q <= S_DONE;
          end else begin
            state_q <= S_WEN_CMD;
          end
        end
        S_WEN_CMD: if (cmd_ready) state_q <= S_WEN_RSP;
        S_WEN_RSP: if (rsp_valid) state_q <= S_WR_CMD;
        S_WR_CMD:  if (cmd_ready) state_q <= S_WR_RSP;
        S_WR_RSP:  if (rsp_valid) state_q <= vol_q ? S_SETTLE : S_POLL_CMD;
        S_SETTLE: if (wait_cnt >= SETTLE_LS) begin
          verify_q <= 1'b1;
          state_q  <= S_RD_LO_CMD;
        end
        S_POLL_CMD: if (cmd_ready) state_q <= S_POLL_RSP;
        S_POLL_RSP: if (rsp_valid) begin
          if (!rsp_data[0]) begin
            verify_q <= 1'b1;
            state_q  <= S_RD_LO_CMD;
          end else if (wait_cnt >= POLL_LIM) begin
            code_q  <= RES_TIMEOUT;
            state_q <= S_DONE;
          end else begin
            state_q <= S_POLL_CMD;
          end
        end
        S_DONE: if (res_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sreg_rmw_seq_chk.sv
module sreg_rmw_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_op,
  input logic [1:0]  cmd_wlen,
  input logic [15:0] cmd_wdata,
  input logic        cmd_read,
  input logic        rsp_ready,
  input logic        res_valid,
  input logic        res_ready,
  input logic [1:0]  res_code,
  input logic [15:0] res_word,
  input logic        vol_q
);
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_wlen)
                                && $stable(cmd_wdata) && $stable(cmd_read));

  assert_cmd_rsp_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready));

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_code) && $stable(res_word));

  assert_res_leave_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> req_ready);

  assert_req_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid && !rsp_ready && !res_valid);

  assert_write_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 8'h01) |-> (cmd_wlen == 2'd2) && !cmd_read);

  assert_wen_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && ((cmd_op == 8'h06) || (cmd_op == 8'h50)) |->
      ((cmd_op == 8'h50) == vol_q) && (cmd_wlen == 2'd0));

  assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_code != 2'd3);

  always_comb begin
    if (!rst_n) begin
      assert_reset_R12: assert (!cmd_valid && !res_valid && !rsp_ready);
    end
  end
endmodule

bind sreg_rmw_seq sreg_rmw_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_wlen  (cmd_wlen),
  .cmd_wdata (cmd_wdata),
  .cmd_read  (cmd_read),
  .rsp_ready (rsp_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_code  (res_code),
  .res_word  (res_word),
  .vol_q     (vol_q)
);

// File: tb/sreg_rmw_seq_tb.sv
module sreg_rmw_seq_tb;
  localparam int POLL_LIM = 40;
  localparam int SETTLE   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_ready, req_volatile = 0;
  logic [15:0] req_mask = 0, req_value = 0;
  logic        cmd_valid, cmd_ready = 0, cmd_read;
  logic [7:0]  cmd_op;
  logic [1:0]  cmd_wlen;
  logic [15:0] cmd_wdata;
  logic        rsp_valid = 0, rsp_ready;
  logic [7:0]  rsp_data = 0;
  logic        res_valid, res_ready = 0;
  logic [1:0]  res_code;
  logic [15:0] res_word;

  sreg_rmw_seq #(.POLL_LIMIT_CYCLES(POLL_LIM), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mask(req_mask),
    .req_value(req_value), .req_volatile(req_volatile),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wlen(cmd_wlen), .cmd_wdata(cmd_wdata), .cmd_read(cmd_read),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code),
    .res_word(res_word)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [15:0] sr = 0, lock = 0, wr_data = 0;
  int busy_cfg = 0, busy_left = 0, wr_n = 0, n_ops = 0, conflicts = 0, t_wr = 0;
  bit wel = 0, wel_pers = 0;
  logic [7:0] op_log [64];
  int t_log [64];

  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid && rsp_ready) conflicts++;
      if (cmd_valid) begin
        automatic logic [7:0]  op = cmd_op;
        automatic logic [15:0] wd = cmd_wdata;
        automatic logic [7:0]  rd = 8'h00;
        cmd_ready = 1'b1;
        if (n_ops < 64) begin
          op_log[n_ops] = op;
          t_log[n_ops]  = cyc;
        end
        n_ops++;
        @(negedge clk);
        cmd_ready = 1'b0;
        @(negedge clk);
        case (op)
          8'h05: begin
            rd = {sr[7:1], sr[0] | (busy_left != 0)};
            if (busy_left != 0) busy_left--;
          end
          8'h35: rd = sr[15:8];
          8'h06: begin wel = 1; wel_pers = 1; end
          8'h50: begin wel = 1; wel_pers = 0; end
          8'h01: begin
            if (wel) begin
              sr = (wd & ~lock) | (sr & lock);
              wr_data = wd;
              wr_n++;
              if (wel_pers) busy_left = busy_cfg;
            end
            wel = 0;
            t_wr = cyc;
          end
          default: ;
        endcase
        rsp_data  = rd;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_data  = 8'h00;
      end
    end
  end

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [15:0] mask;
    logic [15:0] value;
    logic        vol;
    logic [15:0] init;
    logic [15:0] lockm;
    logic [15:0] busy;
    logic [1:0]  code;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h001C, 16'h000C, 1'b0, 16'h000C, 16'h0000, 16'd0,    2'd0},
    '{16'h001C, 16'h0014, 1'b0, 16'h0000, 16'h0000, 16'd3,    2'd0},
    '{16'h4020, 16'h4020, 1'b1, 16'h0200, 16'h0000, 16'd0,    2'd0},
    '{16'h0180, 16'h0100, 1'b0, 16'h00FC, 16'h0000, 16'd1,    2'd0},
    '{16'h003C, 16'h0028, 1'b0, 16'h0004, 16'h0008, 16'd2,    2'd1},
    '{16'hFFFE, 16'h1234, 1'b1, 16'hABCC, 16'h0100, 16'd0,    2'd1},
    '{16'h0040, 16'h0040, 1'b0, 16'h0000, 16'h0000, 16'd1000, 2'd2},
    '{16'h0000, 16'hFFFF, 1'b1, 16'h5A5A, 16'h0000, 16'd0,    2'd0},
    '{16'hFF00, 16'h8100, 1'b1, 16'h7E00, 16'h0000, 16'd0,    2'd0}
  };

  logic [1:0]  got_code;
  logic [15:0] got_word;

  task automatic run_req(input vec_t v, input int hold, input bit probe);
    @(negedge clk);
    sr = v.init; lock = v.lockm; busy_cfg = v.busy; busy_left = 0;
    wel = 0; wr_n = 0; n_ops = 0;
    req_mask = v.mask; req_value = v.value; req_volatile = v.vol; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (probe) check(req_ready == 1'b0, "R1 busy req_ready", req_ready, 0);
    while (!res_valid) @(negedge clk);
    got_code = res_code;
    got_word = res_word;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(res_valid && res_code == got_code && res_word == got_word,
            "R11 result held", {res_valid, res_code}, {1'b1, got_code});
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(req_ready == 1'b1 && res_valid == 1'b0, "R11 back to idle", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !cmd_valid && !rsp_ready && !res_valid, "R12 in reset",
          {req_ready, cmd_valid, rsp_ready, res_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !cmd_valid && !rsp_ready && !res_valid, "R12 after reset",
          {req_ready, cmd_valid, rsp_ready, res_valid}, 4'b1000);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic bit skip = ((v.value & v.mask) == (v.init & v.mask));
      automatic logic [15:0] merged = (v.init & ~v.mask) | (v.value & v.mask);
      automatic logic [15:0] fin = (merged & ~v.lockm) | (v.init & v.lockm);
      automatic logic [15:0] exp_word = (skip || v.code == 2'd2) ? v.init : fin;
      automatic int n_done;
      run_req(v, (i == 1) ? 4 : 0, i == 0);
      n_done = n_ops;
      check(op_log[0] == 8'h05 && op_log[1] == 8'h35, "R2 read order",
            {op_log[0], op_log[1]}, 16'h0535);
      check(got_word == exp_word, skip ? "R3 word" : (v.code == 2 ? "R7 word" : "R9 word"),
            got_word, exp_word);
      check(got_code == v.code, skip ? "R3 code" : (v.code == 2 ? "R7 code" : "R9 code"),
            got_code, v.code);
      check(wr_n == (skip ? 0 : 1), "R3/R5 write count", wr_n, skip ? 0 : 1);
      if (skip) begin
        check(n_ops == 2, "R3 no command after reads", n_ops, 2);
      end else begin
        check(op_log[2] == (v.vol ? 8'h50 : 8'h06), "R4 enable opcode",
              op_log[2], v.vol ? 8'h50 : 8'h06);
        check(op_log[3] == 8'h01, "R5 write opcode", op_log[3], 8'h01);
        check(wr_data == merged, "R5 write data", wr_data, merged);
        if (v.code == 2'd2) begin
          check(op_log[n_ops-1] == 8'h05 && n_ops > 6, "R7 ended on poll",
                op_log[n_ops-1], 8'h05);
          check(cyc - t_wr >= POLL_LIM, "R7 budget used", cyc - t_wr, POLL_LIM);
        end else if (!v.vol) begin
          check(n_ops == 4 + int'(v.busy) + 1 + 2, "R6 poll count", n_ops,
                4 + int'(v.busy) + 3);
          check(op_log[n_ops-2] == 8'h05 && op_log[n_ops-1] == 8'h35,
                "R9 verify reads", {op_log[n_ops-2], op_log[n_ops-1]}, 16'h0535);
        end else begin
          check(n_ops == 6, "R8 no polls", n_ops, 6);
          check(t_log[4] - t_wr >= SETTLE, "R8 settle gap", t_log[4] - t_wr, SETTLE);
          check(op_log[4] == 8'h05 && op_log[5] == 8'h35, "R9 verify reads",
                {op_log[4], op_log[5]}, 16'h0535);
        end
      end
      repeat (8) @(negedge clk);
      check(n_ops == n_done, "R10 no stray command", n_ops, n_done);
    end

    check(conflicts == 0, "R10 cmd/rsp overlap", conflicts, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule